// File: doc/BRIEF.md
# Trigger-Gated DDS Clock Generator

A direct digital synthesis clock source for a timing module. A phase accumulator advances by an active tuning word on every reference clock edge. Its most significant bit is the square-wave output clock, so the output frequency is the reference frequency times the tuning word divided by 2^ACC_W. Software reaches the block through a small write-only register port. Through that port it sets a pending tuning word and a pending phase offset, picks the update source, and then requests an update with a commit write.

The update source is either immediate or one of TRIG_N trigger lines. With the immediate source, the commit itself loads the pending settings into the accumulator. With a trigger line selected, the commit only arms the block. While it is armed, the accumulator is frozen and the output is held low. The block waits for a rising edge on the chosen line, which passes through a two-flop synchronizer first. The edge then loads the phase offset into the accumulator and copies the pending tuning word into the active tuning word, both on the same clock edge. Several units wired to one trigger line therefore start or retune together.

Each unit has a per-unit constant, INIT_PHASE. It is the reset value of both the accumulator and the pending phase offset, so the outputs of several units can be aligned. Software should select the update source before writing the other settings.

Top module: `dds_clkgen`

## Requirements
- R1: After reset the block is in the following state: armed is 0, the source is immediate, and the active and pending tuning words are 0. The accumulator and the pending phase offset both hold INIT_PHASE. clk_out equals bit ACC_W-1 of INIT_PHASE and stays constant. A commit issued before any phase write loads INIT_PHASE.
- R2: On every clock edge with no update and armed at 0, the accumulator adds the active tuning word modulo 2^ACC_W. clk_out equals the accumulator MSB whenever armed is 0.
- R3: The register map is as follows. Address 0 is the source: wr_data bit 3 set selects trigger mode, and wr_data bits 2:0 pick the line. Address 1 is the pending tuning word and address 2 is the pending phase offset. Address 3 is commit, and its data is ignored. Writes to addresses 0 to 2 do not disturb the running output.
- R4: A commit while the immediate source is selected loads the pending phase into the accumulator and the pending tuning word into the active tuning word, on the edge that takes the write. It also clears armed.
- R5: A commit while a trigger source is selected sets armed from the next cycle. While armed is 1 the accumulator holds its value and clk_out is 0.
- R6: Assume a rising edge on the selected line is set up before clock edge A. The update then happens on edge A+2: the accumulator takes the pending phase, the active word takes the pending tuning word, and armed returns to 0. Edges on unselected lines, steady high levels, edges that come before arming, and falling edges cause no update.
- R7: While armed, writes of a new pending tuning word or phase replace the pending values without causing an update.
- R8: A pending tuning word written on the same edge as a trigger update does not reach the active word at that update. The active word takes the previous pending value, and the new value waits for the next update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | ACC_W | Register write data |
| trig_in | input | TRIG_N | Asynchronous trigger lines |
| clk_out | output | 1 | Synthesized clock (accumulator MSB, low while armed) |
| armed | output | 1 | 1 while a triggered update is waiting |

## Verification
The delicate overlap is a trigger-driven update landing on the same edge as a register write of the pending tuning word. The bench raises the selected line two cycles ahead, so that the synchronized edge fires exactly on the write edge. It then follows clk_out for many cycles and compares the output with an accumulator computed arithmetically from the old word. A second armed update must then show the new word. Every sweep, immediate or triggered on each of the eight lines, is judged cycle by cycle against the same arithmetic prediction of the MSB and the armed flag.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Register port addresses
  typedef enum logic [1:0] {
    REG_SRC   = 2'd0,
    REG_TUNE  = 2'd1,
    REG_PHASE = 2'd2,
    REG_GO    = 2'd3
  } dds_reg_e;

endpackage

// File: rtl/dds_trig_edge.sv
module dds_trig_edge #(
  parameter int TRIG_N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRIG_N-1:0] trig_in,
  output logic [TRIG_N-1:0] rise
);

  // One synchronizer and edge detector per line, so that switching
  // the selected line never creates a false edge.
  for (genvar g = 0; g < TRIG_N; g++) begin : g_line
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= trig_in[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign rise[g] = sync_q & ~prev_q;
  end

endmodule

// File: rtl/dds_ctrl.sv
module dds_ctrl
  import dds_pkg::*;
#(
  parameter int              ACC_W      = 32,
  parameter int              TRIG_N     = 8,
  parameter logic [ACC_W-1:0] INIT_PHASE = '0,
  localparam int             LINE_W     = (TRIG_N > 1) ? $clog2(TRIG_N) : 1,
  localparam int             SRC_W      = LINE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [ACC_W-1:0]  wr_data,
  input  logic [TRIG_N-1:0] rise,
  output logic [ACC_W-1:0]  ftw_pend,
  output logic [ACC_W-1:0]  phase_pend,
  output logic              src_trig,
  output logic              armed,
  output logic              fire,
  output logic              load
);

  logic [SRC_W-1:0]  src_q;
  logic [LINE_W-1:0] src_line;
  logic              sel_rise;
  logic              go_wr;
  logic              imm_load;

  assign src_trig = src_q[SRC_W-1];
  assign src_line = src_q[LINE_W-1:0];
  assign go_wr    = wr_en && (wr_addr == REG_GO);

  always_comb begin
    sel_rise = 1'b0;
    for (int i = 0; i < TRIG_N; i++) begin
      if (src_line == LINE_W'(i)) sel_rise = rise[i];
    end
  end

  assign fire     = armed && src_trig && sel_rise;
  assign imm_load = go_wr && !src_trig;
  assign load     = fire || imm_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q      <= '0;
      ftw_pend   <= '0;
      phase_pend <= INIT_PHASE;
    end else if (wr_en) begin
      case (wr_addr)
        REG_SRC:   src_q      <= wr_data[SRC_W-1:0];
        REG_TUNE:  ftw_pend   <= wr_data;
        REG_PHASE: phase_pend <= wr_data;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (go_wr) begin
      armed <= src_trig;
    end else if (fire) begin
      armed <= 1'b0;
    end
  end

endmodule

// File: rtl/dds_accum.sv
module dds_accum #(
  parameter int               ACC_W      = 32,
  parameter logic [ACC_W-1:0] INIT_PHASE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             hold,
  input  logic [ACC_W-1:0] ftw_pend,
  input  logic [ACC_W-1:0] phase_pend,
  output logic [ACC_W-1:0] acc,
  output logic [ACC_W-1:0] ftw_act,
  output logic             clk_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= INIT_PHASE;
      ftw_act <= '0;
    end else if (load) begin
      acc     <= phase_pend;
      ftw_act <= ftw_pend;
    end else if (!hold) begin
      acc     <= acc + ftw_act;
    end
  end

  assign clk_out = acc[ACC_W-1] & ~hold;

endmodule

// File: rtl/dds_clkgen.sv
module dds_clkgen #(
  parameter int               ACC_W      = 32,
  parameter int               TRIG_N     = 8,
  parameter logic [ACC_W-1:0] INIT_PHASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [ACC_W-1:0]  wr_data,
  input  logic [TRIG_N-1:0] trig_in,
  output logic              clk_out,
  output logic              armed
);

  logic [TRIG_N-1:0] rise;
  logic [ACC_W-1:0]  ftw_pend;
  logic [ACC_W-1:0]  phase_pend;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  ftw_act;
  logic              src_trig;
  logic              fire;
  logic              load;

  dds_trig_edge #(.TRIG_N(TRIG_N)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig_in),
    .rise    (rise)
  );

  dds_ctrl #(
    .ACC_W      (ACC_W),
    .TRIG_N     (TRIG_N),
    .INIT_PHASE (INIT_PHASE)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rise       (rise),
    .ftw_pend   (ftw_pend),
    .phase_pend (phase_pend),
    .src_trig   (src_trig),
    .armed      (armed),
    .fire       (fire),
    .load       (load)
  );

  dds_accum #(
    .ACC_W      (ACC_W),
    .INIT_PHASE (INIT_PHASE)
  ) u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .hold       (armed),
    .ftw_pend   (ftw_pend),
    .phase_pend (phase_pend),
    .acc        (acc),
    .ftw_act    (ftw_act),
    .clk_out    (clk_out)
  );

endmodule

// File: rtl/dds_clkgen_chk.sv
module dds_clkgen_chk
  import dds_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             src_trig,
  input logic             armed,
  input logic             fire,
  input logic             load,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] ftw_act,
  input logic [ACC_W-1:0] ftw_pend,
  input logic [ACC_W-1:0] phase_pend
);

  logic go_wr;
  assign go_wr = wr_en && (wr_addr == REG_GO);

  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !load) |=> (acc == $past(acc) + $past(ftw_act)));

  p_imm_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && !src_trig) |=> (!armed && acc == $past(phase_pend) && ftw_act == $past(ftw_pend)));

  p_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && src_trig) |=> armed);

  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !load) |=> (acc == $past(acc)));

  p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !go_wr) |=> !armed);

  p_no_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !fire && !go_wr) |=> armed);

  p_old_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (ftw_act == $past(ftw_pend) && acc == $past(phase_pend)));

endmodule

bind dds_clkgen dds_clkgen_chk #(.ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .src_trig   (src_trig),
  .armed      (armed),
  .fire       (fire),
  .load       (load),
  .acc        (acc),
  .ftw_act    (ftw_act),
  .ftw_pend   (ftw_pend),
  .phase_pend (phase_pend)
);

// File: tb/test_dds_clkgen.sv
`timescale 1ns/1ps
module test_dds_clkgen;

  localparam int          CLK_P = 10;
  localparam logic [31:0] INIT  = 32'hC000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  trig_in = '0;
  logic        clk_out;
  logic        armed;

  int n_chk = 0;
  int n_err = 0;

  // Bench prediction of the block state
  logic [31:0] m_acc, m_ftw, m_pf, m_pp;
  logic [3:0]  m_src;
  logic        m_armed;

  always #(CLK_P/2) clk = ~clk;

  dds_clkgen #(.ACC_W(32), .TRIG_N(8), .INIT_PHASE(INIT)) i_dds_clkgen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_in(trig_in), .clk_out(clk_out), .armed(armed)
  );

  task automatic chk_out(input string req);
    logic [1:0] exp;
    exp = {m_acc[31] & ~m_armed, m_armed};
    n_chk++;
    if ({clk_out, armed} !== exp) begin
      n_err++;
      $display("FAIL %s {clk_out,armed} act=%b exp=%b t=%0t", req, {clk_out, armed}, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic adv();
    if (!m_armed) m_acc = m_acc + m_ftw;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      tick();
      adv();
      chk_out(req);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string req);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
    case (a)
      2'd0: begin adv(); m_src = d[3:0]; end
      2'd1: begin adv(); m_pf = d; end
      2'd2: begin adv(); m_pp = d; end
      default: begin
        if (!m_src[3]) begin
          m_acc = m_pp; m_ftw = m_pf; m_armed = 1'b0;
        end else begin
          adv(); m_armed = 1'b1;
        end
      end
    endcase
    chk_out(req);
  endtask

  // Raise line k; the update lands on the third edge (R6)
  task automatic fire(input int k, input string req, input bit do_wr, input logic [31:0] wd);
    trig_in[k] = 1'b1;
    tick(); chk_out(req);
    tick(); chk_out(req);
    if (do_wr) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = wd; end
    tick();
    wr_en = 1'b0;
    m_acc = m_pp; m_ftw = m_pf; m_armed = 1'b0;
    if (do_wr) m_pf = wd;
    chk_out(req);
    trig_in[k] = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    m_acc = INIT; m_ftw = '0; m_pf = '0; m_pp = INIT; m_src = '0; m_armed = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    chk_out("R1");
    idle(5, "R1");

    // R1: commit before any phase write loads the reset phase
    wr(2'd1, 32'h1000_0000, "R3");
    wr(2'd3, 32'hFFFF_FFFF, "R1");
    idle(20, "R2");

    // Immediate sweep (R2, R3, R4)
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, (i + 1) * 32'h0300_0000 + i, "R3");
      wr(2'd2, i * 32'h2345_6789, "R3");
      wr(2'd3, 32'h0, "R4");
      idle(40, "R2");
    end

    // Triggered sweep over all lines (R5, R6, R7)
    for (int k = 0; k < 8; k++) begin
      wr(2'd0, 32'(8 + k), "R3");
      wr(2'd1, 32'h0500_0000 * (k + 1), "R3");
      wr(2'd2, 32'h1111_1111 * k, "R3");
      wr(2'd3, 32'h0, "R5");
      idle(3, "R5");
      trig_in[(k + 1) % 8] = 1'b1;
      idle(5, "R6");
      trig_in[(k + 1) % 8] = 1'b0;
      idle(2, "R6");
      wr(2'd1, 32'h0700_0001 * (k + 2), "R7");
      wr(2'd2, 32'h7654_3210 + k, "R7");
      idle(2, "R7");
      fire(k, "R6", 1'b0, '0);
      idle(30, "R2");
    end

    // Level held before arming, then falling edge while armed (R6)
    wr(2'd0, 32'd10, "R3");
    trig_in[2] = 1'b1;
    idle(5, "R6");
    wr(2'd3, 32'h0, "R5");
    idle(6, "R6");
    trig_in[2] = 1'b0;
    idle(4, "R6");
    fire(2, "R6", 1'b0, '0);
    idle(20, "R2");

    // Same-edge update and tuning write (R8)
    wr(2'd0, 32'd13, "R3");
    wr(2'd1, 32'h0900_0000, "R3");
    wr(2'd2, 32'h0000_1234, "R3");
    wr(2'd3, 32'h0, "R5");
    idle(2, "R5");
    fire(5, "R8", 1'b1, 32'h2200_0000);
    idle(40, "R8");
    wr(2'd3, 32'h0, "R8");
    idle(3, "R8");
    fire(5, "R8", 1'b0, '0);
    idle(40, "R8");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule